// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Sequencer

This block is the read engine on the device side of a NOR-type memory that shares one bus between address and x16 data. It serves two kinds of read. In asynchronous reads, an address-valid strobe captures the address and the addressed word is then driven for as long as chip enable stays low. In synchronous burst reads, a single address-valid beat at a clock edge starts a sequence. The sequence waits out a programmable initial latency and then presents one word per clock.

Three burst orderings are available: continuous, linear-8 and linear-16. Each linear ordering can wrap inside its aligned group or run straight through. The initial latency grows when the start address is not 4-word aligned. In continuous mode with a mid-range latency setting, the engine also pauses at internal 8-word and 128-word boundaries. The engine drops its ready output whenever it inserts such waits. The memory array sits outside the block and is reached through a combinational read port.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the output driver is off, ready is high and the configured mode is asynchronous, so a strobe pulse with no configuration write performs an asynchronous read.
- R2: With chip enable low, write enable high and mode 0, the address is taken from the bus on every clock edge that sees address-valid low. From the edge that first sees it high again, the word at the last captured address is driven. It stays driven while chip enable is low, and only while output enable is low.
- R3: With mode not 0, an edge that sees address-valid low, chip enable low and write enable high starts a burst at the bus address.
- R4: The first burst word is driven after the edge that is D plus (start modulo 4) edges after the start edge, where D is the dummy setting. Ready is low and the driver is off in the cycles before it.
- R5: Mode 1 (continuous) drives the next address on each following edge, incrementing without wrapping inside any group.
- R6: Modes 2 and 3 (linear, 8 and 16 words) with wrap set drive exactly L words at addresses group_base + ((start + i) mod L). After that the driver turns off and ready is high.
- R7: Linear modes with wrap clear drive the L words start, start+1, and so on, across the group edge, then stop as in R6.
- R8: In continuous mode with D from 5 to 10, the engine inserts wait cycles after driving a word whose address has low 3 bits 111. It inserts one wait cycle, or two when the low 7 bits are all ones. During these cycles ready is low and the driver is off. With any other D, no waits are inserted.
- R9: Chip enable high turns the driver off in the same cycle and returns the engine to idle with ready high after the next edge, at any point of a read.
- R10: A configuration write strobe loads mode (0 async, 1 continuous, 2 linear-8, 3 linear-16), wrap and D. A D written below 2 is stored as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; must be high to read |
| oe_ni | input | 1 | Output enable, active low |
| adv_ni | input | 1 | Address-valid strobe, active low |
| ad_i | input | AW | Address phase of the shared bus |
| ad_o | output | DW | Data phase of the shared bus |
| ad_oe_o | output | 1 | Bus driver enable |
| rdy_o | output | 1 | Ready; low during inserted waits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Read mode to load |
| cfg_wrap_i | input | 1 | Wrap enable to load |
| cfg_dummy_i | input | DUMW | Dummy-cycle count to load |
| mem_addr_o | output | AW | Array read address |
| mem_data_i | input | DW | Array read data |

## Verification
The bench builds the block with its defaults: a 23-bit address, x16 data, a 4-bit dummy field and a boundary-penalty window of 5 to 10. This lets random starts range over the whole address space, and latency settings fall inside and outside the penalty window. Directed bursts beginning just below a 128-word boundary reach the two-cycle wait. The bench also covers every misalignment offset, the clamped dummy value, and aborts during latency and during data.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_LIN8  = 2'd2,
    MODE_LIN16 = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALATCH,
    ST_ADATA,
    ST_BLAT,
    ST_BDATA,
    ST_BWAIT
  } seq_st_e;
endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_pkg::*;
#(
  parameter int DUMW      = 4,
  parameter int MIN_DUMMY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      mode_i,
  input  logic            wrap_i,
  input  logic [DUMW-1:0] dummy_i,
  output rd_mode_e        mode_o,
  output logic            wrap_o,
  output logic [DUMW-1:0] dummy_o
);
  localparam logic [DUMW-1:0] DMIN = DUMW'(MIN_DUMMY);
  localparam logic [DUMW-1:0] DMAX = {DUMW{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MODE_ASYNC;
      wrap_o  <= 1'b0;
      dummy_o <= DMAX;
    end else if (we_i) begin
      mode_o  <= rd_mode_e'(mode_i);
      wrap_o  <= wrap_i;
      dummy_o <= (dummy_i < DMIN) ? DMIN : dummy_i;
    end
  end
endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_pkg::*;
#(
  parameter int AW        = 23,
  parameter int SMALL_BLK = 8,
  parameter int BIG_BLK   = 128
) (
  input  logic [AW-1:0] cur_i,
  input  rd_mode_e      mode_i,
  input  logic          wrap_i,
  output logic [AW-1:0] nxt_o,
  output logic          small_bnd_o,
  output logic          big_bnd_o
);
  localparam int SMALL_LG = $clog2(SMALL_BLK);
  localparam int BIG_LG   = $clog2(BIG_BLK);

  logic [AW-1:0] inc;
  logic [AW-1:0] grp_mask;
  logic          lin;

  assign inc      = cur_i + AW'(1);
  assign lin      = (mode_i == MODE_LIN8) || (mode_i == MODE_LIN16);
  assign grp_mask = (mode_i == MODE_LIN8) ? AW'(7) : AW'(15);

  always_comb begin
    if (lin && wrap_i) nxt_o = (cur_i & ~grp_mask) | (inc & grp_mask);
    else               nxt_o = inc;
  end

  assign small_bnd_o = &cur_i[SMALL_LG-1:0];
  assign big_bnd_o   = &cur_i[BIG_LG-1:0];
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int DUMW      = 4,
  parameter int MIN_DUMMY = 2,
  parameter int BND_LO    = 5,
  parameter int BND_HI    = 10,
  parameter int SMALL_BLK = 8,
  parameter int BIG_BLK   = 128
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_ni,
  input  logic            we_ni,
  input  logic            oe_ni,
  input  logic            adv_ni,
  input  logic [AW-1:0]   ad_i,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            rdy_o,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_mode_i,
  input  logic            cfg_wrap_i,
  input  logic [DUMW-1:0] cfg_dummy_i,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_data_i
);
  localparam int CNT_W = DUMW + 2;
  localparam int WRD_W = 4;

  rd_mode_e        cfg_mode;
  logic            cfg_wrap;
  logic [DUMW-1:0] cfg_dummy;

  seq_st_e          st_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WRD_W-1:0] words_q;
  logic             pend_q;

  logic [AW-1:0]    nxt_addr;
  logic             small_bnd, big_bnd;
  logic             lin, bnd_en, last_word, start_ok;
  logic [CNT_W-1:0] lat_init;
  logic [WRD_W-1:0] len_m1;

  burst_cfg_reg #(.DUMW(DUMW), .MIN_DUMMY(MIN_DUMMY)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .mode_i  (cfg_mode_i),
    .wrap_i  (cfg_wrap_i),
    .dummy_i (cfg_dummy_i),
    .mode_o  (cfg_mode),
    .wrap_o  (cfg_wrap),
    .dummy_o (cfg_dummy)
  );

  burst_addr_next #(.AW(AW), .SMALL_BLK(SMALL_BLK), .BIG_BLK(BIG_BLK)) i_next (
    .cur_i       (addr_q),
    .mode_i      (cfg_mode),
    .wrap_i      (cfg_wrap),
    .nxt_o       (nxt_addr),
    .small_bnd_o (small_bnd),
    .big_bnd_o   (big_bnd)
  );

  assign lin       = (cfg_mode == MODE_LIN8) || (cfg_mode == MODE_LIN16);
  assign len_m1    = (cfg_mode == MODE_LIN8) ? WRD_W'(7) : WRD_W'(15);
  assign last_word = lin && (words_q == len_m1);
  assign bnd_en    = (cfg_mode == MODE_CONT) &&
                     (cfg_dummy >= DUMW'(BND_LO)) && (cfg_dummy <= DUMW'(BND_HI));
  // total initial wait = dummy + start offset inside the 4-word group
  assign lat_init  = CNT_W'(cfg_dummy) + CNT_W'(ad_i[1:0]) - CNT_W'(1);
  assign start_ok  = !adv_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      words_q <= '0;
      pend_q  <= 1'b0;
    end else if (ce_ni) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE, ST_ADATA: begin
          if (start_ok) begin
            addr_q  <= ad_i;
            words_q <= '0;
            if (cfg_mode == MODE_ASYNC) begin
              st_q <= ST_ALATCH;
            end else begin
              st_q  <= ST_BLAT;
              cnt_q <= lat_init;
            end
          end
        end
        ST_ALATCH: begin
          if (!adv_ni) addr_q <= ad_i;
          else         st_q   <= ST_ADATA;
        end
        ST_BLAT: begin
          if (cnt_q == '0) st_q  <= ST_BDATA;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_BDATA: begin
          if (last_word) begin
            st_q <= ST_IDLE;
          end else begin
            addr_q  <= nxt_addr;
            words_q <= words_q + WRD_W'(1);
            if (bnd_en && small_bnd) begin
              st_q   <= ST_BWAIT;
              pend_q <= big_bnd;
            end
          end
        end
        ST_BWAIT: begin
          if (pend_q) pend_q <= 1'b0;
          else        st_q   <= ST_BDATA;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o = addr_q;
  assign ad_o       = mem_data_i;
  assign ad_oe_o    = !ce_ni && !oe_ni && ((st_q == ST_ADATA) || (st_q == ST_BDATA));
  assign rdy_o      = !((st_q == ST_BLAT) || (st_q == ST_BWAIT));
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
  import burst_pkg::*;
#(
  parameter int AW        = 23,
  parameter int DUMW      = 4,
  parameter int MIN_DUMMY = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ce_ni,
  input logic            ad_oe_o,
  input logic            rdy_o,
  input logic [AW-1:0]   mem_addr_o,
  input seq_st_e         st_q,
  input rd_mode_e        cfg_mode,
  input logic [DUMW-1:0] cfg_dummy
);
  // R9
  drive_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !ce_ni);

  // R4
  no_data_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> rdy_o);

  // R5
  cont_incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BDATA && cfg_mode == MODE_CONT && $past(st_q == ST_BDATA) &&
     $past(cfg_mode == MODE_CONT)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(1)));

  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (rdy_o && !ad_oe_o));

  // R10
  dummy_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dummy >= DUMW'(MIN_DUMMY));
endmodule

bind burst_read_seq burst_seq_chk #(.AW(AW), .DUMW(DUMW), .MIN_DUMMY(MIN_DUMMY)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .ad_oe_o    (ad_oe_o),
  .rdy_o      (rdy_o),
  .mem_addr_o (mem_addr_o),
  .st_q       (st_q),
  .cfg_mode   (cfg_mode),
  .cfg_dummy  (cfg_dummy)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int DUMW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, adv_n = 1'b1;
  logic [AW-1:0] ad_i = '0;
  logic [DW-1:0] ad_o;
  logic ad_oe, rdy;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_wrap = 1'b0;
  logic [DUMW-1:0] cfg_dummy = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return a[15:0] ^ {a[22:16], a[22:14]} ^ 16'h5a3c;
  endfunction

  assign mem_data = mem_fn(mem_addr);

  burst_read_seq i_burst_read_seq (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .adv_ni(adv_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe), .rdy_o(rdy),
    .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_wrap_i(cfg_wrap),
    .cfg_dummy_i(cfg_dummy), .mem_addr_o(mem_addr), .mem_data_i(mem_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int mode, input bit wrap, input int dummy);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_wrap = wrap; cfg_dummy = DUMW'(dummy);
    step();
    cfg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] next_addr(input int mode, input bit wrap,
                                               input logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = (mode == 2) ? AW'(7) : AW'(15);
    if (mode >= 2 && wrap) return (a & ~m) | ((a + AW'(1)) & m);
    return a + AW'(1);
  endfunction

  function automatic int bnd_waits(input int mode, input int dummy, input logic [AW-1:0] a);
    int w;
    w = 0;
    if (mode == 1 && dummy >= 5 && dummy <= 10) begin
      if (a[2:0] == 3'b111) w++;
      if (a[6:0] == 7'h7f) w++;
    end
    return w;
  endfunction

  // runs a burst of n words (n = L for linear); ends with chip enable high
  task automatic run_burst(input int mode, input bit wrap, input int dummy,
                           input logic [AW-1:0] start, input int n);
    logic [AW-1:0] a;
    int waits;
    a = start;
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; ad_i = start;
    step();
    adv_n = 1'b1; ad_i = '0;
    for (int w = 0; w < n; w++) begin
      waits = (w == 0) ? dummy + int'(start[1:0]) : bnd_waits(mode, dummy, a - AW'(0));
      if (w != 0) waits = bnd_waits(mode, dummy, a_prev(mode, wrap, a, start, w));
      for (int k = 0; k < waits; k++) begin
        chk((w == 0) ? "R4 rdy in latency" : "R8 rdy in wait", 32'(rdy), 32'd0);
        chk((w == 0) ? "R4 drv in latency" : "R8 drv in wait", 32'(ad_oe), 32'd0);
        step();
      end
      chk(mode == 1 ? "R5 drv" : (wrap ? "R6 drv" : "R7 drv"), 32'(ad_oe), 32'd1);
      chk(mode == 1 ? "R5 data" : (wrap ? "R6 data" : "R7 data"), 32'(ad_o), 32'(mem_fn(a)));
      chk(w == 0 ? "R4 rdy first" : "R8 rdy data", 32'(rdy), 32'd1);
      a = next_addr(mode, wrap, a);
      step();
    end
    if (mode >= 2) begin
      chk(wrap ? "R6 end drv" : "R7 end drv", 32'(ad_oe), 32'd0);
      chk(wrap ? "R6 end rdy" : "R7 end rdy", 32'(rdy), 32'd1);
    end
    ce_n = 1'b1;
    #1 chk("R9 drv off", 32'(ad_oe), 32'd0);
    step();
    chk("R9 rdy idle", 32'(rdy), 32'd1);
  endtask

  // previous word address of word w (the one just driven)
  function automatic logic [AW-1:0] a_prev(input int mode, input bit wrap,
                                           input logic [AW-1:0] a,
                                           input logic [AW-1:0] start, input int w);
    logic [AW-1:0] p;
    p = start;
    for (int i = 1; i < w; i++) p = next_addr(mode, wrap, p);
    return p;
  endfunction

  task automatic async_read(input logic [AW-1:0] a1, input logic [AW-1:0] a2, input string req);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; ad_i = a1;
    step();
    ad_i = a2;
    step();
    adv_n = 1'b1; ad_i = '0;
    step();
    chk({req, " async drv"}, 32'(ad_oe), 32'd1);
    chk({req, " async data"}, 32'(ad_o), 32'(mem_fn(a2)));
    chk({req, " async rdy"}, 32'(rdy), 32'd1);
    oe_n = 1'b1;
    #1 chk("R2 oe high off", 32'(ad_oe), 32'd0);
    oe_n = 1'b0;
    step();
    chk("R2 data held", 32'(ad_o), 32'(mem_fn(a2)));
    ce_n = 1'b1;
    step();
  endtask

  initial begin
    int mode, dummy, nw;
    bit wrap;
    logic [AW-1:0] st;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk("R1 drv reset", 32'(ad_oe), 32'd0);
    chk("R1 rdy reset", 32'(rdy), 32'd1);
    rst_n = 1'b1;
    step();
    async_read(23'h12345, 23'h0abcd, "R1");
    async_read(23'h7ffff, 23'h40001, "R2");

    // R3 R5 R8 directed: 128-word boundary inside penalty window
    set_cfg(1, 0, 6);
    run_burst(1, 0, 6, 23'h00007c, 14);
    set_cfg(1, 0, 10);
    run_burst(1, 0, 10, 23'h0001fd, 12);
    // R8 outside window: no waits
    set_cfg(1, 0, 4);
    run_burst(1, 0, 4, 23'h00007c, 14);
    set_cfg(1, 0, 11);
    run_burst(1, 0, 11, 23'h0000fe, 6);
    // R10 clamp of dummy
    set_cfg(1, 0, 0);
    run_burst(1, 0, 2, 23'h000003, 3);
    // R6 R7 directed
    set_cfg(2, 1, 3);
    run_burst(2, 1, 3, 23'h000035, 8);
    set_cfg(3, 1, 5);
    run_burst(3, 1, 5, 23'h00002e, 16);
    set_cfg(2, 0, 7);
    run_burst(2, 0, 7, 23'h000006, 8);
    set_cfg(3, 0, 2);
    run_burst(3, 0, 2, 23'h00007a, 16);

    // R9 abort during latency, then a fresh burst
    set_cfg(1, 0, 12);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; ad_i = 23'h000100;
    step();
    adv_n = 1'b1;
    step(); step();
    chk("R9 rdy low before abort", 32'(rdy), 32'd0);
    ce_n = 1'b1;
    step();
    chk("R9 rdy after abort", 32'(rdy), 32'd1);
    chk("R9 drv after abort", 32'(ad_oe), 32'd0);
    run_burst(1, 0, 12, 23'h000101, 4);

    // random bursts
    for (int i = 0; i < 40; i++) begin
      mode = 1 + int'($urandom_range(2, 0));
      wrap = 1'($urandom_range(1, 0));
      dummy = int'($urandom_range(15, 2));
      st = AW'($urandom);
      if ($urandom_range(3, 0) == 0) st = {st[AW-1:7], 7'h78 | 7'(st[2:0])};
      nw = (mode == 1) ? int'($urandom_range(40, 1)) : (mode == 2 ? 8 : 16);
      set_cfg(mode, wrap, dummy);
      run_burst(mode, wrap, dummy, st, nw);
    end

    // back to asynchronous mode
    set_cfg(0, 0, 9);
    async_read(23'h000010, 23'h3ffff0, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule